// File: doc/BRIEF.md
# Bit-Skewed Read Response Unpacker

This block turns the 32-bit receive words of a serial bridge back into the bytes of a register read. The bridge shifts each returned byte by one bit position, so a byte is split across two words: its upper seven bits come in one word and its lowest bit comes in the next one. The block is told how many bytes to expect before the first word arrives. It takes receive words on a valid/ready stream and presents the rebuilt bytes in order on a byte stream with valid/ready. A one-cycle done pulse marks the end of the read.

A one-byte read is coded differently from a longer read. The single word then holds the whole byte at bit 1. In a read of two or more bytes, the first word gives only seven bits, and each later word completes the byte before it. The final word uses its own layout: it completes the next-to-last byte and also carries the whole last byte.

Top module: `skew_rd_unpack`

## Requirements
- R1: After reset, `out_valid`, `done` and `rx_ready` are low.
- R2: A `start` pulse with `start_len` of 1 or more begins a read when the block is idle. A `start` that arrives while a read is in progress is ignored, and so is a `start` with `start_len` of 0.
- R3: In a read of length 1, the single word gives the output byte `rx_word[8:1]`.
- R4: In a read of length n ≥ 2, the first word sets bits 7..1 of byte 0 from `rx_word[6:0]`. This word does not produce an output byte.
- R5: Each word between the first and the final one produces the previous byte, with `rx_word[8]` as its bit 0. Its `rx_word[6:0]` becomes bits 7..1 of the following byte.
- R6: The final word of a read with n ≥ 2 produces two bytes in this order. The first is byte n-2, with `rx_word[10]` as its bit 0. The second is byte n-1, which equals `rx_word[8:1]`. For example, first word 0x3D666748 followed by final word 0x7EF1AFCA gives the bytes 0x91 and 0xE5.
- R7: An n-byte read accepts exactly n receive words. Once they are taken, `rx_ready` stays low until the next accepted `start`.
- R8: While `out_valid` is high and `out_ready` is low, `out_byte` holds its value. `rx_ready` is low while a byte is waiting.
- R9: `done` is high for exactly one cycle. That cycle follows the clock edge at which the last byte is handed off. The block is then idle.
- R10: Bits of a receive word that R3 to R6 do not name have no effect on the output bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a read |
| start_len | input | LEN_W | Number of bytes in the read |
| rx_valid | input | 1 | Receive word is present |
| rx_ready | output | 1 | Block takes the receive word |
| rx_word | input | WORD_W | Receive word from the bridge |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Rebuilt byte |
| done | output | 1 | One-cycle pulse at the end of the read |

## Verification
A wrong held upper part or a misplaced low bit shows up as a wrong byte. It appears one word later, when that byte is completed and emitted. A word counter that is off by one shows up at the end of the read, as a missing or extra byte or a `done` that never comes. A stale "first word" or "single" flag breaks the very next read from its first output byte. Backpressure faults show as `out_byte` changing while stalled, or as a word being taken while a byte is still waiting.

// File: rtl/skew_rd_unpack.sv
module skew_rd_unpack #(
  parameter int LEN_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  start_len,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [WORD_W-1:0] rx_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              done
);

  logic             busy, single, first, olast, q1v;
  logic [LEN_W-1:0] left;
  logic [6:0]       hi7;
  logic [7:0]       q1b;

  wire accept   = rx_valid && rx_ready;
  wire last_wd  = (left == LEN_W'(1));
  wire handoff  = out_valid && out_ready;

  assign rx_ready = busy && (left != '0) && !out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; single <= 1'b0; first <= 1'b0; left <= '0;
      hi7 <= '0; out_valid <= 1'b0; out_byte <= '0; olast <= 1'b0;
      q1v <= 1'b0; q1b <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy && start_len != '0) begin
        busy   <= 1'b1;
        left   <= start_len;
        single <= (start_len == LEN_W'(1));
        first  <= 1'b1;
      end
      if (accept) begin
        left  <= left - LEN_W'(1);
        first <= 1'b0;
        if (single) begin
          out_valid <= 1'b1; out_byte <= rx_word[8:1]; olast <= 1'b1;
        end else if (first) begin
          hi7 <= rx_word[6:0];
        end else if (last_wd) begin
          out_valid <= 1'b1; out_byte <= {hi7, rx_word[10]}; olast <= 1'b0;
          q1v <= 1'b1; q1b <= rx_word[8:1];
        end else begin
          out_valid <= 1'b1; out_byte <= {hi7, rx_word[8]}; olast <= 1'b0;
          hi7 <= rx_word[6:0];
        end
      end
      if (handoff) begin
        if (q1v) begin
          out_byte <= q1b; q1v <= 1'b0; olast <= 1'b1;
        end else begin
          out_valid <= 1'b0;
          if (olast) begin
            done <= 1'b1;
            busy <= 1'b0;
          end
        end
      end
    end
  end

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid && !done && !rx_ready);

  a_r3_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
    accept && single |=> out_valid && out_byte == $past(rx_word[8:1]));

  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte));

  a_r8_no_take_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rx_ready);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_handoff: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(handoff) && !out_valid && !rx_ready);

endmodule

// File: tb/test_skew_rd_unpack.sv
module test_skew_rd_unpack;
  logic        clk = 0, rst_n = 0, start = 0, rx_valid = 0, out_ready = 1;
  logic [7:0]  start_len = 0;
  logic [31:0] rx_word = 0;
  logic        rx_ready, out_valid, done;
  logic [7:0]  out_byte;

  skew_rd_unpack i_skew_rd_unpack (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte), .done(done));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, gn = 0, dn = 0, last_hs = -10, done_cyc = -10;
  bit stall = 0, was_stalled = 0;
  logic [7:0] held, got [16], expb [16];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (was_stalled && out_valid) chk(out_byte == held, "R8 hold", out_byte, held);
      was_stalled = out_valid && !out_ready;
      held = out_byte;
      if (out_valid && out_ready) begin got[gn] = out_byte; gn++; last_hs = cyc; end
      if (done) begin dn++; done_cyc = cyc; end
    end
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) out_ready <= stall ? ($urandom % 3 != 0) : 1'b1;

  task automatic send(input logic [31:0] w);
    rx_word = w; rx_valid = 1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic begin_read(input int n);
    start = 1; start_len = 8'(n); @(negedge clk); start = 0;
  endtask

  task automatic wait_done(input int d0);
    int t = 0;
    while (dn == d0 && t < 200) begin @(negedge clk); t++; end
  endtask

  // encode n bytes into n receive words; unnamed bits come from noise
  task automatic run_read(input int n, input logic [31:0] noise, input string req);
    logic [31:0] w;
    int d0 = dn;
    gn = 0;
    begin_read(n);
    if (n == 1) send((noise & ~32'h1FE) | {23'd0, expb[0], 1'b0});
    else begin
      send((noise & ~32'h7F) | {25'd0, expb[0][7:1]});
      for (int k = 1; k < n - 1; k++) begin
        w = (noise & ~32'h17F) | {23'd0, expb[k-1][0], 1'b0, expb[k][7:1]};
        send(w);
      end
      w = (noise & ~32'h5FE) | {21'd0, expb[n-2][0], 1'b0, expb[n-1], 1'b0};
      send(w);
    end
    wait_done(d0);
    chk(gn == n, {req, " R7 count"}, gn, n);
    for (int k = 0; k < n && k < gn; k++) chk(got[k] == expb[k], req, got[k], expb[k]);
    chk(dn == d0 + 1, "R9 one done", dn, d0 + 1);
    chk(done_cyc == last_hs + 1, "R9 done timing", done_cyc, last_hs + 1);
    @(negedge clk);
    chk(!done && !rx_ready, "R9 idle after", {done, rx_ready}, 0);
  endtask

  task automatic t_reset;
    chk(!out_valid && !done && !rx_ready, "R1 reset", {out_valid, done, rx_ready}, 0);
  endtask

  task automatic t_single;
    expb[0] = 8'hA0; run_read(1, 32'h677C8600, "R3 single");
    expb[0] = 8'h3C; run_read(1, 32'h0, "R3 single");
  endtask

  task automatic t_doc_pair;
    int d0 = dn;
    gn = 0; begin_read(2);
    send(32'h3D666748);
    chk(gn == 0 && !out_valid, "R4 no byte on first word", gn, 0);
    send(32'h7EF1AFCA);
    wait_done(d0);
    chk(gn == 2 && got[0] == 8'h91, "R6 byte n-2", got[0], 8'h91);
    chk(gn == 2 && got[1] == 8'hE5, "R6 last byte", got[1], 8'hE5);
  endtask

  task automatic t_middle;
    int d0 = dn;
    gn = 0; begin_read(3);
    send(32'h3D666748); send(32'h352FF5A6);
    repeat (2) @(negedge clk);
    chk(gn == 1 && got[0] == 8'h91, "R5 middle completes byte", got[0], 8'h91);
    send(32'h0000_0000);
    wait_done(d0);
    chk(gn == 3 && got[1] == 8'h4C, "R5 upper bits kept", got[1], 8'h4C);
  endtask

  task automatic t_multi;
    for (int k = 0; k < 6; k++) expb[k] = 8'(8'h5A ^ (k * 37));
    run_read(6, 32'h0, "R5 multi");
  endtask

  task automatic t_noise;
    for (int k = 0; k < 5; k++) expb[k] = 8'(k * 29 + 3);
    run_read(5, 32'hFFFF_FFFF, "R10 ones noise");
    run_read(5, 32'hA5C3_1E96, "R10 mixed noise");
  endtask

  task automatic t_stall;
    stall = 1;
    for (int k = 0; k < 8; k++) expb[k] = 8'(8'hF0 - k * 17);
    run_read(8, 32'h1234_5678, "R8 stalled");
    stall = 0;
  endtask

  task automatic t_ignored_start;
    int d0 = dn;
    begin_read(0);
    repeat (3) @(negedge clk);
    chk(!rx_ready, "R2 zero length ignored", rx_ready, 0);
    gn = 0; begin_read(2);
    begin_read(5);
    send(32'h0000_0040); send(32'h0000_0402);
    wait_done(d0);
    chk(gn == 2, "R2 start while busy ignored", gn, 2);
    chk(got[0] == 8'h81 && got[1] == 8'h01, "R2 bytes", {got[0], got[1]}, 16'h8101);
    rx_word = 32'hFFFF_FFFF; rx_valid = 1;
    repeat (4) @(negedge clk);
    rx_valid = 0;
    chk(gn == 2 && !out_valid, "R7 extra word not taken", gn, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1; @(negedge clk);
    t_reset;
    t_single; t_doc_pair; t_middle; t_multi; t_noise; t_stall; t_ignored_start;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule